// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block chooses, for each of the two ALU operands of a five-stage in-order pipeline, whether the value comes from the register file or is bypassed from a later stage. It compares the source register fields of the instruction in the decode/execute latch with the destinations of the instructions in the execute/memory and memory/writeback latches. It then drives a 2-bit select and the selected 32-bit operand for source A and for source B.

Everything is combinational, so a dependent instruction gets its fresh operand in the same cycle and no stall is needed. Stores and branches write no register, so those stages never forward. A set-status or overflow condition redirects the destination to status register 30. Register 0 is never forwarded.

Top module: `fwd_select_unit`

## Requirements
- R1: Source A is the register field in bits 21..17 of the decode/execute instruction.
- R2: Source B is bits 16..12 of the decode/execute instruction when its opcode (bits 31..27) is 00000. For any other opcode it is bits 26..22.
- R3: The destination of the execute/memory and memory/writeback instructions is their bits 26..22. It is replaced by register 30 while that stage's set-status or overflow flag is high.
- R4: A stage matches a source only when its destination equals the source and the destination is nonzero. A source field of 0 always selects the register-file operand.
- R5: A stage whose store or branch flag is high never forwards, even when its destination matches.
- R6: When both later stages match a source, the execute/memory result is selected.
- R7: The select encoding is 0 for the execute/memory result, 1 for the writeback data, 2 for the register-file operand and 3 for constant zero. Each operand output equals the input named by its select in the same evaluation, with no clock involved.
- R8: Source A and source B are decided independently, each with its own select and operand output.
- R9: The select outputs never take the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dx_inst | input | 32 | Instruction in the decode/execute latch |
| xm_inst | input | 32 | Instruction in the execute/memory latch |
| mw_inst | input | 32 | Instruction in the memory/writeback latch |
| xm_store | input | 1 | Execute/memory instruction is a store |
| xm_branch | input | 1 | Execute/memory instruction is a branch |
| xm_setst | input | 1 | Execute/memory instruction sets the status register |
| xm_ovf | input | 1 | Execute/memory instruction overflowed |
| mw_store | input | 1 | Memory/writeback instruction is a store |
| mw_branch | input | 1 | Memory/writeback instruction is a branch |
| mw_setst | input | 1 | Memory/writeback instruction sets the status register |
| mw_ovf | input | 1 | Memory/writeback instruction overflowed |
| xm_result | input | 32 | ALU result held in the execute/memory latch |
| wb_data | input | 32 | Data being written back from the memory/writeback stage |
| rf_a | input | 32 | Register-file value for source A |
| rf_b | input | 32 | Register-file value for source B |
| sel_a | output | 2 | Forward select for source A |
| sel_b | output | 2 | Forward select for source B |
| op_a | output | 32 | Selected operand A |
| op_b | output | 32 | Selected operand B |

## Verification
Two decisions can land in the same evaluation. The first is a double match, where both later stages target one source and priority must pick execute/memory. The second is a split forward, where A bypasses from one stage while B bypasses from the other or reads the register file. The random stimulus draws register numbers from a small pool that includes 0 and 30 and sets the stage flags often, so these collisions occur many times. Each vector is judged against a bench model of the selects and operands.

// File: rtl/fwd_select_unit.sv
module fwd_select_unit #(
  parameter int XLEN       = 32,
  parameter int STATUS_REG = 30
) (
  input  logic [31:0]     dx_inst,
  input  logic [31:0]     xm_inst,
  input  logic [31:0]     mw_inst,
  input  logic            xm_store,
  input  logic            xm_branch,
  input  logic            xm_setst,
  input  logic            xm_ovf,
  input  logic            mw_store,
  input  logic            mw_branch,
  input  logic            mw_setst,
  input  logic            mw_ovf,
  input  logic [XLEN-1:0] xm_result,
  input  logic [XLEN-1:0] wb_data,
  input  logic [XLEN-1:0] rf_a,
  input  logic [XLEN-1:0] rf_b,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b,
  output logic [XLEN-1:0] op_a,
  output logic [XLEN-1:0] op_b
);

  localparam logic [1:0] SEL_XM   = 2'd0;
  localparam logic [1:0] SEL_WB   = 2'd1;
  localparam logic [1:0] SEL_RF   = 2'd2;
  localparam logic [1:0] SEL_ZERO = 2'd3;
  localparam logic [4:0] STAT     = 5'(STATUS_REG);

  logic [4:0] src_a, src_b, xm_dst, mw_dst;
  logic       xm_live, mw_live;
  logic       a_xm, a_mw, b_xm, b_mw;

  // R1, R2: operand fields of the instruction being executed
  assign src_a = dx_inst[21:17];
  assign src_b = (dx_inst[31:27] == 5'b00000) ? dx_inst[16:12] : dx_inst[26:22];

  // R3: destination redirection to the status register
  assign xm_dst = (xm_setst || xm_ovf) ? STAT : xm_inst[26:22];
  assign mw_dst = (mw_setst || mw_ovf) ? STAT : mw_inst[26:22];

  // R4, R5: a stage can forward only with a real, nonzero destination
  assign xm_live = !xm_store && !xm_branch && (xm_dst != 5'd0);
  assign mw_live = !mw_store && !mw_branch && (mw_dst != 5'd0);

  assign a_xm = xm_live && (src_a == xm_dst);
  assign a_mw = mw_live && (src_a == mw_dst);
  assign b_xm = xm_live && (src_b == xm_dst);
  assign b_mw = mw_live && (src_b == mw_dst);

  // R6, R9: priority encoders, newest stage first
  assign sel_a = a_xm ? SEL_XM : (a_mw ? SEL_WB : SEL_RF);
  assign sel_b = b_xm ? SEL_XM : (b_mw ? SEL_WB : SEL_RF);

  // R7, R8: operand muxes
  always_comb begin
    unique case (sel_a)
      SEL_XM:   op_a = xm_result;
      SEL_WB:   op_a = wb_data;
      SEL_RF:   op_a = rf_a;
      SEL_ZERO: op_a = '0;
      default:  op_a = '0;
    endcase
    unique case (sel_b)
      SEL_XM:   op_b = xm_result;
      SEL_WB:   op_b = wb_data;
      SEL_RF:   op_b = rf_b;
      SEL_ZERO: op_b = '0;
      default:  op_b = '0;
    endcase
  end

endmodule

module fwd_select_checker #(
  parameter int XLEN = 32
) (
  input logic [31:0]     dx_inst,
  input logic            xm_store,
  input logic            xm_branch,
  input logic            xm_setst,
  input logic            mw_store,
  input logic            mw_branch,
  input logic [XLEN-1:0] xm_result,
  input logic [XLEN-1:0] wb_data,
  input logic [XLEN-1:0] rf_a,
  input logic [XLEN-1:0] rf_b,
  input logic [1:0]      sel_a,
  input logic [1:0]      sel_b,
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b
);
  always_comb begin
    if (!$isunknown({sel_a, sel_b})) begin
      a_r9_sel_never3: assert (sel_a != 2'd3 && sel_b != 2'd3);
      if (!$isunknown({op_a, xm_result, wb_data, rf_a}))
        a_r7_op_a_follows_sel: assert ((sel_a == 2'd0 && op_a == xm_result) ||
                                       (sel_a == 2'd1 && op_a == wb_data) ||
                                       (sel_a == 2'd2 && op_a == rf_a) ||
                                       (sel_a == 2'd3 && op_a == '0));
      if (!$isunknown({op_b, xm_result, wb_data, rf_b}))
        a_r8_op_b_follows_sel: assert ((sel_b == 2'd0 && op_b == xm_result) ||
                                       (sel_b == 2'd1 && op_b == wb_data) ||
                                       (sel_b == 2'd2 && op_b == rf_b) ||
                                       (sel_b == 2'd3 && op_b == '0));
      if (!$isunknown(dx_inst) && dx_inst[21:17] == 5'd0)
        a_r4_zero_src_reads_rf: assert (sel_a == 2'd2);
      if (!$isunknown({xm_store, xm_branch, mw_store, mw_branch}) &&
          (xm_store || xm_branch) && (mw_store || mw_branch))
        a_r5_no_forward_from_store_branch: assert (sel_a == 2'd2 && sel_b == 2'd2);
      if (!$isunknown({dx_inst, xm_setst, xm_store, xm_branch}) &&
          xm_setst && !xm_store && !xm_branch && dx_inst[21:17] == 5'd30)
        a_r3_status_dest_forwards: assert (sel_a == 2'd0);
    end
  end
endmodule

bind fwd_select_unit fwd_select_checker #(.XLEN(XLEN)) u_chk (
  .dx_inst(dx_inst), .xm_store(xm_store), .xm_branch(xm_branch),
  .xm_setst(xm_setst), .mw_store(mw_store), .mw_branch(mw_branch),
  .xm_result(xm_result), .wb_data(wb_data), .rf_a(rf_a), .rf_b(rf_b),
  .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b)
);

// File: tb/tb_fwd_select_unit.sv
`timescale 1ns/1ps
module tb_fwd_select_unit;
  logic clk = 0;
  always #5 clk = ~clk;

  logic [31:0] dx_inst, xm_inst, mw_inst;
  logic xm_store, xm_branch, xm_setst, xm_ovf;
  logic mw_store, mw_branch, mw_setst, mw_ovf;
  logic [31:0] xm_result, wb_data, rf_a, rf_b;
  logic [1:0] sel_a, sel_b;
  logic [31:0] op_a, op_b;

  int checks = 0, errors = 0;
  bit done = 0;

  fwd_select_unit dut (.*);

  function automatic logic [1:0] exp_sel(input logic [4:0] src);
    logic [4:0] dx, dm;
    logic hx, hm;
    dx = (xm_setst | xm_ovf) ? 5'd30 : xm_inst[26:22];
    dm = (mw_setst | mw_ovf) ? 5'd30 : mw_inst[26:22];
    hx = (src == dx) && (dx != 0) && !xm_store && !xm_branch;
    hm = (src == dm) && (dm != 0) && !mw_store && !mw_branch;
    if (hx) return 2'd0;
    if (hm) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [4:0] exp_srcb();
    return (dx_inst[31:27] == 0) ? dx_inst[16:12] : dx_inst[26:22];
  endfunction

  function automatic logic [31:0] exp_op(input logic [1:0] s, input logic [31:0] rf);
    case (s)
      2'd0: return xm_result;
      2'd1: return wb_data;
      2'd2: return rf;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check2(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [1:0] ea, eb;
    ea = exp_sel(dx_inst[21:17]);
    eb = exp_sel(exp_srcb());
    check2({tag, " sel_a"}, {30'd0, sel_a}, {30'd0, ea});
    check2({tag, " sel_b"}, {30'd0, sel_b}, {30'd0, eb});
    check2({tag, " op_a"}, op_a, exp_op(ea, rf_a));
    check2({tag, " op_b"}, op_b, exp_op(eb, rf_b));
  endtask

  function automatic logic [31:0] mk(input logic [4:0] opc, input logic [4:0] f1,
                                     input logic [4:0] fa, input logic [4:0] f3);
    return {opc, f1, fa, f3, 12'h0};
  endfunction

  task automatic clear();
    dx_inst = 0; xm_inst = 0; mw_inst = 0;
    {xm_store, xm_branch, xm_setst, xm_ovf} = 0;
    {mw_store, mw_branch, mw_setst, mw_ovf} = 0;
    xm_result = 32'hAAAA0001; wb_data = 32'hBBBB0002;
    rf_a = 32'hCCCC0003; rf_b = 32'hDDDD0004;
  endtask

  task automatic apply_and_check(input string tag, input logic [1:0] want_a,
                                 input logic [1:0] want_b);
    @(negedge clk);
    check2({tag, " direct sel_a"}, {30'd0, sel_a}, {30'd0, want_a});
    check2({tag, " direct sel_b"}, {30'd0, sel_b}, {30'd0, want_b});
    check_all(tag);
  endtask

  function automatic logic [4:0] pick_reg();
    case ($urandom % 6)
      0: return 5'd0;
      1: return 5'd30;
      2: return 5'd1;
      3: return 5'd2;
      4: return 5'd3;
      default: return 5'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk); clear();
    apply_and_check("R4 idle", 2'd2, 2'd2);

    clear(); dx_inst = mk(5'd1, 5'd0, 5'd5, 5'd0); xm_inst = mk(5'd1, 5'd5, 0, 0);
    apply_and_check("R1 srcA xm hit", 2'd0, 2'd2);

    clear(); dx_inst = mk(5'd0, 5'd9, 5'd0, 5'd7); mw_inst = mk(5'd1, 5'd7, 0, 0);
    apply_and_check("R2 rtype srcB", 2'd2, 2'd1);

    clear(); dx_inst = mk(5'd4, 5'd7, 5'd0, 5'd9); mw_inst = mk(5'd1, 5'd7, 0, 0);
    apply_and_check("R2 itype srcB", 2'd2, 2'd1);

    clear(); dx_inst = mk(5'd1, 5'd0, 5'd30, 5'd0); xm_inst = mk(5'd1, 5'd4, 0, 0); xm_ovf = 1;
    apply_and_check("R3 ovf redirect", 2'd0, 2'd2);

    clear(); dx_inst = mk(5'd1, 5'd4, 5'd30, 5'd0); mw_inst = mk(5'd1, 5'd4, 0, 0); mw_setst = 1;
    apply_and_check("R3 setst redirect", 2'd1, 2'd2);

    clear(); dx_inst = mk(5'd0, 5'd0, 5'd0, 5'd0);
    apply_and_check("R4 zero dest", 2'd2, 2'd2);

    clear(); dx_inst = mk(5'd1, 5'd6, 5'd6, 5'd0); xm_inst = mk(5'd1, 5'd6, 0, 0); xm_store = 1;
    apply_and_check("R5 store blocked", 2'd2, 2'd2);

    clear(); dx_inst = mk(5'd1, 5'd6, 5'd6, 5'd0); xm_inst = mk(5'd1, 5'd6, 0, 0);
    mw_inst = mk(5'd1, 5'd6, 0, 0); xm_branch = 1;
    apply_and_check("R5 branch falls to mw", 2'd1, 2'd1);

    clear(); dx_inst = mk(5'd1, 5'd8, 5'd8, 5'd0); xm_inst = mk(5'd1, 5'd8, 0, 0); mw_inst = mk(5'd1, 5'd8, 0, 0);
    apply_and_check("R6 xm priority", 2'd0, 2'd0);

    clear(); dx_inst = mk(5'd1, 5'd3, 5'd2, 5'd0); xm_inst = mk(5'd1, 5'd2, 0, 0); mw_inst = mk(5'd1, 5'd3, 0, 0);
    apply_and_check("R8 split", 2'd0, 2'd1);

    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      dx_inst = mk(($urandom % 3 == 0) ? 5'd0 : 5'($urandom), pick_reg(), pick_reg(), pick_reg());
      xm_inst = mk(5'($urandom), pick_reg(), 5'($urandom), 5'($urandom));
      mw_inst = mk(5'($urandom), pick_reg(), 5'($urandom), 5'($urandom));
      xm_store = ($urandom % 5 == 0); xm_branch = ($urandom % 5 == 0);
      xm_setst = ($urandom % 6 == 0); xm_ovf = ($urandom % 6 == 0);
      mw_store = ($urandom % 5 == 0); mw_branch = ($urandom % 5 == 0);
      mw_setst = ($urandom % 6 == 0); mw_ovf = ($urandom % 6 == 0);
      xm_result = $urandom; wb_data = $urandom; rf_a = $urandom; rf_b = $urandom;
      @(negedge clk);
      check_all("R7 random");
      checks++;
      if (sel_a == 2'd3 || sel_b == 2'd3) begin
        errors++;
        $display("FAIL R9: actual %0d/%0d expected below 3", sel_a, sel_b);
      end
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule